// File: doc/BRIEF.md
# Flash Page Correction Status Tally

This block sums the per-chunk correction reports for one flash page. A decoder upstream supplies one 8-bit status code for each chunk of the page. Each code arrives with a valid strobe. A start pulse marks the first chunk of a page, and a last flag marks its final chunk. The block sorts every code into one of four kinds: clean, corrected, erased or uncorrectable. It then keeps page-level running figures.

After the last chunk, the block raises a one-cycle done pulse. In that same cycle it presents the page result:
- the total number of corrected bits;
- the largest bitflip count seen in any single chunk;
- how many chunks failed;
- how many chunks were erased;
- a page-failure flag.

Firmware or a sequencer reads the result while done is high, or at any later time before the next page ends.

Code zero means a clean chunk. Code 0xFF marks an erased chunk. Code 0xFE, and any other code above a correction ceiling of 40, marks an uncorrectable chunk. Codes from 1 up to the ceiling are corrected bit counts.

Top module: `ecc_page_tally`

## Requirements
- R1: After reset, done is low and every result output reads zero.
- R2: A valid code of 0x00 is a clean chunk and changes no result figure.
- R3: A valid code of 0xFF is an erased chunk. It adds one to the erased count and changes neither the corrected total, the maximum nor the failure figures.
- R4: A valid code of 0xFE is an uncorrectable chunk. It adds one to the failed count and sets the page-failure flag. The flag is high exactly when the failed count is non-zero.
- R5: Any valid code above the ceiling (0x29 to 0xFD at the default ceiling of 40) is treated as uncorrectable, exactly like 0xFE.
- R6: A valid code from 1 to the ceiling is added to the corrected total, and the maximum output reports the largest such code in the page.
- R7: When the page-failure flag is set, the maximum output reads zero in place of a bitflip count.
- R8: The corrected total saturates at 2^SUM_W-1. The failed and erased counts saturate at 2^CNT_W-1. None of them wraps.
- R9: The start pulse clears the running figures. If the start pulse comes in the same cycle as a valid chunk, that chunk is the first chunk of the new page. A start pulse without a valid chunk only clears the figures.
- R10: done is high for exactly the one cycle after the clock edge that samples a valid chunk with the last flag set. The results for that page are present in that same cycle.
- R11: The result outputs change only in a done cycle. A last flag without valid has no effect.
- R12: A new page may start in the cycle right after the previous page's last chunk, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| page_start | input | 1 | Pulse that clears the running figures for a new page |
| code_valid | input | 1 | A chunk status code is present this cycle |
| code | input | 8 | Chunk status code |
| code_last | input | 1 | With code_valid, marks the last chunk of the page |
| done | output | 1 | One-cycle pulse: the page result is ready |
| total_corr | output | SUM_W | Saturating sum of the corrected bit counts |
| max_flips | output | 8 | Largest per-chunk bitflip count; zero when the page failed |
| fail_cnt | output | CNT_W | Saturating count of uncorrectable chunks |
| erased_cnt | output | CNT_W | Saturating count of erased chunks |
| page_fail | output | 1 | At least one chunk of the page was uncorrectable |

## Verification
The bench builds the block with SUM_W=10 and CNT_W=5, keeping the default ceiling of 40. At these widths, a page of 30 chunks that each report 40 corrected bits overruns the 1023 limit of the total. Likewise, 35 erased or 35 failed chunks pass the count limit of 31, so every saturation path is reached within a short run. Random pages of one to eight chunks, some of them back to back, cover how the four code classes mix within a page. Directed pages cover the boundary codes 0x28, 0x29, 0xFD, 0xFE and 0xFF.

// File: rtl/ecc_tally_pkg.sv
package ecc_tally_pkg;

  localparam int STATUS_W = 8;

  typedef logic [STATUS_W-1:0] status_t;

  typedef enum logic [1:0] {
    CHUNK_CLEAN = 2'd0,
    CHUNK_FIXED = 2'd1,
    CHUNK_BLANK = 2'd2,
    CHUNK_BAD   = 2'd3
  } chunk_kind_e;

  // Sort one status code. The erased marker is tested before the ceiling
  // because it lies above the ceiling but is not a failure.
  function automatic chunk_kind_e kind_of(status_t c, status_t ceil_v,
                                          status_t blank_v, status_t bad_v);
    if (c == '0)                         return CHUNK_CLEAN;
    else if (c == blank_v)               return CHUNK_BLANK;
    else if (c == bad_v || c > ceil_v)   return CHUNK_BAD;
    else                                 return CHUNK_FIXED;
  endfunction

endpackage

// File: rtl/ecc_code_decode.sv
module ecc_code_decode
  import ecc_tally_pkg::*;
#(
  parameter status_t CEIL    = 8'd40,
  parameter status_t BLANK_C = 8'hFF,
  parameter status_t BAD_C   = 8'hFE
) (
  input  status_t     code,
  output chunk_kind_e kind,
  output status_t     fixed_bits
);

  assign kind       = kind_of(code, CEIL, BLANK_C, BAD_C);
  assign fixed_bits = (kind == CHUNK_FIXED) ? code : '0;

endmodule

// File: rtl/ecc_tally_acc.sv
module ecc_tally_acc
  import ecc_tally_pkg::*;
#(
  parameter int SUM_W = 16,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              fire,
  input  logic              last,
  input  chunk_kind_e       kind,
  input  status_t           fixed_bits,
  output logic              done,
  output logic [SUM_W-1:0]  res_total,
  output status_t           res_max,
  output logic [CNT_W-1:0]  res_bad,
  output logic [CNT_W-1:0]  res_blank,
  output logic              res_fail
);

  localparam int SUM_EXT = SUM_W + 1;

  function automatic logic [SUM_W-1:0] sat_sum(logic [SUM_W-1:0] a, status_t b);
    logic [SUM_W:0] s;
    s = {1'b0, a} + SUM_EXT'(b);
    return s[SUM_W] ? '1 : s[SUM_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] sat_inc(logic [CNT_W-1:0] a, logic hit);
    return (hit && a != '1) ? a + 1'b1 : a;
  endfunction

  logic [SUM_W-1:0] run_total, base_total, nxt_total;
  status_t          run_max, base_max, nxt_max;
  logic [CNT_W-1:0] run_bad, base_bad, nxt_bad;
  logic [CNT_W-1:0] run_blank, base_blank, nxt_blank;
  logic             closing;

  always_comb begin
    base_total = start ? '0 : run_total;
    base_max   = start ? '0 : run_max;
    base_bad   = start ? '0 : run_bad;
    base_blank = start ? '0 : run_blank;
    nxt_total  = sat_sum(base_total, fixed_bits);
    nxt_max    = (fixed_bits > base_max) ? fixed_bits : base_max;
    nxt_bad    = sat_inc(base_bad, kind == CHUNK_BAD);
    nxt_blank  = sat_inc(base_blank, kind == CHUNK_BLANK);
  end

  assign closing = fire && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_total <= '0;
      run_max   <= '0;
      run_bad   <= '0;
      run_blank <= '0;
    end else if (fire) begin
      run_total <= nxt_total;
      run_max   <= nxt_max;
      run_bad   <= nxt_bad;
      run_blank <= nxt_blank;
    end else if (start) begin
      run_total <= '0;
      run_max   <= '0;
      run_bad   <= '0;
      run_blank <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done      <= 1'b0;
      res_total <= '0;
      res_max   <= '0;
      res_bad   <= '0;
      res_blank <= '0;
      res_fail  <= 1'b0;
    end else begin
      done <= closing;
      if (closing) begin
        res_total <= nxt_total;
        res_max   <= (nxt_bad != '0) ? '0 : nxt_max;
        res_bad   <= nxt_bad;
        res_blank <= nxt_blank;
        res_fail  <= (nxt_bad != '0);
      end
    end
  end

endmodule

// File: rtl/ecc_page_tally.sv
module ecc_page_tally
  import ecc_tally_pkg::*;
#(
  parameter int      SUM_W   = 16,
  parameter int      CNT_W   = 8,
  parameter status_t CEIL    = 8'd40,
  parameter status_t BLANK_C = 8'hFF,
  parameter status_t BAD_C   = 8'hFE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             page_start,
  input  logic             code_valid,
  input  logic [7:0]       code,
  input  logic             code_last,
  output logic             done,
  output logic [SUM_W-1:0] total_corr,
  output logic [7:0]       max_flips,
  output logic [CNT_W-1:0] fail_cnt,
  output logic [CNT_W-1:0] erased_cnt,
  output logic             page_fail
);

  // Named internal events, exposed for the bound checker.
  chunk_kind_e chunk_kind;
  status_t     chunk_bits;

  ecc_code_decode #(
    .CEIL(CEIL), .BLANK_C(BLANK_C), .BAD_C(BAD_C)
  ) u_decode (
    .code       (code),
    .kind       (chunk_kind),
    .fixed_bits (chunk_bits)
  );

  ecc_tally_acc #(
    .SUM_W(SUM_W), .CNT_W(CNT_W)
  ) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (page_start),
    .fire       (code_valid),
    .last       (code_last),
    .kind       (chunk_kind),
    .fixed_bits (chunk_bits),
    .done       (done),
    .res_total  (total_corr),
    .res_max    (max_flips),
    .res_bad    (fail_cnt),
    .res_blank  (erased_cnt),
    .res_fail   (page_fail)
  );

endmodule

// File: rtl/ecc_page_tally_chk.sv
module ecc_page_tally_chk
  import ecc_tally_pkg::*;
#(
  parameter int      SUM_W   = 16,
  parameter int      CNT_W   = 8,
  parameter status_t CEIL    = 8'd40,
  parameter status_t BLANK_C = 8'hFF
) (
  input logic             clk,
  input logic             rst_n,
  input logic             code_valid,
  input logic [7:0]       code,
  input logic             code_last,
  input chunk_kind_e      chunk_kind,
  input logic             done,
  input logic [SUM_W-1:0] total_corr,
  input logic [7:0]       max_flips,
  input logic [CNT_W-1:0] fail_cnt,
  input logic [CNT_W-1:0] erased_cnt,
  input logic             page_fail
);

  p_clean_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid && code == 8'h00) |-> chunk_kind == CHUNK_CLEAN);

  p_fail_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    page_fail == (fail_cnt != '0));

  p_ceiling_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid && code > CEIL && code != BLANK_C) |-> chunk_kind == CHUNK_BAD);

  p_max_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    max_flips <= CEIL);

  p_fail_hides_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
    page_fail |-> max_flips == '0);

  p_done_follows_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid && code_last) |=> done);

  p_done_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(code_valid && code_last));

  p_hold_between_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(total_corr) && $stable(max_flips) && $stable(fail_cnt)
               && $stable(erased_cnt) && $stable(page_fail)));

endmodule

bind ecc_page_tally ecc_page_tally_chk #(
  .SUM_W(SUM_W), .CNT_W(CNT_W), .CEIL(CEIL), .BLANK_C(BLANK_C)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .code_valid (code_valid),
  .code       (code),
  .code_last  (code_last),
  .chunk_kind (chunk_kind),
  .done       (done),
  .total_corr (total_corr),
  .max_flips  (max_flips),
  .fail_cnt   (fail_cnt),
  .erased_cnt (erased_cnt),
  .page_fail  (page_fail)
);

// File: tb/tb_ecc_page_tally.sv
`timescale 1ns/1ps
module tb_ecc_page_tally;

  localparam int SW = 10;
  localparam int CW = 5;
  localparam int SUM_MAX = (1 << SW) - 1;
  localparam int CNT_MAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          page_start = 1'b0;
  logic          code_valid = 1'b0;
  logic [7:0]    code = '0;
  logic          code_last = 1'b0;
  logic          done;
  logic [SW-1:0] total_corr;
  logic [7:0]    max_flips;
  logic [CW-1:0] fail_cnt;
  logic [CW-1:0] erased_cnt;
  logic          page_fail;

  int n_checks = 0;
  int n_err = 0;

  // model of the page in progress
  int m_total, m_max, m_bad, m_blank;

  always #4 clk = ~clk;

  ecc_page_tally #(.SUM_W(SW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .page_start(page_start), .code_valid(code_valid),
    .code(code), .code_last(code_last), .done(done), .total_corr(total_corr),
    .max_flips(max_flips), .fail_cnt(fail_cnt), .erased_cnt(erased_cnt),
    .page_fail(page_fail)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lim(input int v, input int top);
    return (v > top) ? top : v;
  endfunction

  // Model of one chunk, written as a range test on the code.
  task automatic model_add(input logic [7:0] c);
    if (c == 8'hFF)       m_blank++;
    else if (c >= 8'h29)  m_bad++;
    else if (c != 8'h00) begin
      m_total += int'(c);
      if (int'(c) > m_max) m_max = int'(c);
    end
  endtask

  task automatic model_clear();
    m_total = 0; m_max = 0; m_bad = 0; m_blank = 0;
  endtask

  task automatic check_result(input string req);
    chk({req, " done"}, int'(done), 1);
    chk({req, " total"}, int'(total_corr), lim(m_total, SUM_MAX));
    chk({req, " max"}, int'(max_flips), (m_bad != 0) ? 0 : m_max);
    chk({req, " failcnt"}, int'(fail_cnt), lim(m_bad, CNT_MAX));
    chk({req, " erased"}, int'(erased_cnt), lim(m_blank, CNT_MAX));
    chk({req, " flag"}, int'(page_fail), (m_bad != 0) ? 1 : 0);
  endtask

  // One chunk: drive at a falling edge, sample at the next falling edge.
  task automatic put(input logic [7:0] c, input bit st, input bit lst, input string req);
    page_start = st; code_valid = 1'b1; code = c; code_last = lst;
    if (st) model_clear();
    model_add(c);
    @(negedge clk);
    page_start = 1'b0; code_valid = 1'b0; code_last = 1'b0;
    if (lst) check_result(req);
    else chk({req, " done low mid-page"}, int'(done), 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic repeat_page(input logic [7:0] c, input int n, input string req);
    for (int i = 0; i < n; i++) put(c, i == 0, i == n - 1, req);
  endtask

  function automatic logic [7:0] rnd_code();
    int r;
    r = int'($urandom % 8);
    case (r)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'hFE;
      3: return 8'(8'h29 + ($urandom % 213));
      default: return 8'(1 + ($urandom % 40));
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_clear();
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", int'(done), 0);
    chk("R1 total", int'(total_corr), 0);
    chk("R1 max", int'(max_flips), 0);
    chk("R1 failcnt", int'(fail_cnt), 0);
    chk("R1 erased", int'(erased_cnt), 0);
    chk("R1 flag", int'(page_fail), 0);

    // R2 clean chunks
    put(8'h00, 1, 0, "R2"); put(8'h00, 0, 0, "R2"); put(8'h00, 0, 1, "R2");
    // R10 done lasts a single cycle
    @(negedge clk);
    chk("R10 done one cycle", int'(done), 0);

    // R3 erased chunks
    put(8'hFF, 1, 0, "R3"); put(8'd5, 0, 0, "R3"); put(8'hFF, 0, 1, "R3");

    // R6 corrected counts, including the ceiling itself
    put(8'd3, 1, 0, "R6"); put(8'd40, 0, 0, "R6"); put(8'd7, 0, 1, "R6");

    // R4 and R7: marker 0xFE fails the page and hides the maximum
    put(8'd10, 1, 0, "R4 R7"); put(8'hFE, 0, 0, "R4 R7"); put(8'd2, 0, 1, "R4 R7");

    // R5 codes just above the ceiling and just below the bad marker
    put(8'h29, 1, 1, "R5");
    put(8'd9, 1, 0, "R5"); put(8'hFD, 0, 1, "R5");

    // R11 hold: last without valid, results stable, done low
    idle(1);
    code_last = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R11 done", int'(done), 0);
      chk("R11 total held", int'(total_corr), m_total);
      chk("R11 failcnt held", int'(fail_cnt), m_bad);
    end
    code_last = 1'b0;

    // R9 lone start pulse discards a half page
    put(8'd20, 1, 0, "R9"); put(8'hFE, 0, 0, "R9");
    page_start = 1'b1;
    @(negedge clk);
    page_start = 1'b0;
    model_clear();
    put(8'd4, 0, 1, "R9 lone start");

    // R8 saturation of each figure
    repeat_page(8'd40, 30, "R8 total");
    repeat_page(8'hFE, 35, "R8 failcnt");
    repeat_page(8'hFF, 35, "R8 erased");

    // R12 back-to-back pages, mixed with random pages (R2..R7, R9)
    for (int p = 0; p < 60; p++) begin
      int n;
      n = 1 + int'($urandom % 8);
      for (int k = 0; k < n; k++)
        put(rnd_code(), k == 0, k == n - 1, (p % 2 == 0) ? "R12" : "R6");
      if ($urandom % 3 == 0) idle(1 + int'($urandom % 3));
    end

    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule